// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Retransmit

This block is a single-clock FIFO controller with a 9-bit data path and a parameterised depth (2048 words by default). Words go in through a write port with an active-low write enable and come out through a registered read port with an active-low read enable. The read/write handshake has two styles. The style is captured while master reset is held and is kept until the next master reset.

In standard style, every word, including the first, is requested with read enable. The read flag reports whether the FIFO holds data, and the write flag reports whether it has free space. In fall-through style, the oldest word is presented on the output without a request, and read enable consumes it. The read flag then means that no valid word is present, and the write flag means that the storage is full.

Status outputs cover half-full, almost-empty and almost-full. The two thresholds come from offset values that an external offset block supplies. A partial reset empties the FIFO and keeps the handshake style. A retransmit request rewinds the read side to memory location zero after a short setup phase, so that data already read can be read again.

Top module: `dualModeFifo`

## Requirements
- R1: After master reset, in standard style (`modeSel` low during reset) `readFlag` is 0 and `writeFlag` is 1. In fall-through style (`modeSel` high) `readFlag` is 1 and `writeFlag` is 0. In both styles `halfFullN` is 1, `almostFullN` is 1, `almostEmptyN` is 0 and `rdData` is all zeroes.
- R2: `modeSel` is sampled only on clock edges while `mrstN` is low. Changing it at any other time has no effect on the handshake style.
- R3: In standard style, a read with `rdEnN` low while `readFlag` is 1 puts the oldest word on `rdData` at that clock edge. Words come out in write order. `readFlag` is 1 exactly when at least one word is stored, and `writeFlag` is 0 exactly when DEPTH words are stored.
- R4: In fall-through style, a word written into an empty FIFO is on `rdData`, with `readFlag` 0, after the third rising edge, counting the write edge as the first. No read request is needed. Each later word is presented on the edge at which `rdEnN` is low, and words come out in write order. `writeFlag` is 1 only when the memory holds DEPTH words.
- R5: A write while the memory is full and a read while the FIFO is empty are both ignored. No word is lost or duplicated, and `rdData` keeps its value.
- R6: `halfFullN` is 0 while the occupancy is greater than DEPTH/2, and 1 otherwise. In fall-through style, occupancy counts the word held on the output.
- R7: `almostEmptyN` is 0 while the occupancy is at most `aeOffset`. `almostFullN` is 0 while the occupancy is at least DEPTH minus `afOffset`.
- R8: Taking `prstN` low asynchronously empties the FIFO, clears `rdData` to zero and restores the flags listed in R1 for the style in use. The style is kept, whatever `modeSel` is during the partial reset.
- R9: In standard style, `rtN` low at a clock edge while `rdEnN` and `wrEnN` are both high starts a two-cycle retransmit setup. `readFlag` is 0 for both cycles and then returns to 1. Reads then restart at location zero, and each needs `rdEnN`. This holds while fewer than DEPTH words have been written since reset.
- R10: In fall-through style, the same request drives `readFlag` to 1 for the two setup cycles. When it returns to 0, the word at location zero is already on `rdData`.
- R11: Writes attempted during retransmit setup are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| mrstN | input | 1 | Master reset, asynchronous, active low |
| prstN | input | 1 | Partial reset, asynchronous, active low |
| modeSel | input | 1 | Handshake style select, captured during master reset (1 = fall-through) |
| wrEnN | input | 1 | Write enable, active low |
| wrData | input | 9 | Write data |
| rdEnN | input | 1 | Read enable, active low |
| rtN | input | 1 | Retransmit request, active low |
| aeOffset | input | log2(DEPTH) | Almost-empty threshold |
| afOffset | input | log2(DEPTH) | Almost-full threshold distance from full |
| rdData | output | 9 | Registered read data |
| readFlag | output | 1 | Standard: 1 = data present; fall-through: 1 = no valid word on output |
| writeFlag | output | 1 | Standard: 0 = full; fall-through: 1 = full |
| halfFullN | output | 1 | 0 when occupancy exceeds half the depth |
| almostEmptyN | output | 1 | 0 when occupancy is at or below aeOffset |
| almostFullN | output | 1 | 0 when occupancy is at or above DEPTH minus afOffset |

## Verification
A wrong pointer or occupancy count is visible at the ports on the next sampled edge. The level flags (R3, R6, R7) then disagree with a count of accepted writes minus accepted reads, and the next read returns a word out of write order. A broken fall-through stage or retransmit sequencer shows up in the exact cycle in which `readFlag` should change (the third edge after a write, or the edge after the two setup cycles) as a wrong flag level or a wrong word on `rdData`. Random traffic in both styles drives occupancy through empty, the thresholds and full, so a counting error that builds up over many cycles surfaces as a data mismatch within one pass through the memory.

// File: rtl/fifoPkg.sv
package fifoPkg;

  // Strobes from the control to the datapath, one bundle per cycle.
  typedef struct packed {
    logic memWrite;  // store wrData at the write address
    logic outLoad;   // load the output register from the read address
  } fifoStrobes_t;

  typedef enum logic {
    MODE_STANDARD = 1'b0,
    MODE_FALLTHRU = 1'b1
  } fifoMode_e;

endpackage

// File: rtl/fifoDatapath.sv
module fifoDatapath
  import fifoPkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2048,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] storage [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.memWrite) storage[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdData <= '0;
    else if (strobes.outLoad) rdData <= storage[rdAddr];
  end

endmodule

// File: rtl/fifoControl.sv
module fifoControl
  import fifoPkg::*;
#(
  parameter int DEPTH    = 2048,
  parameter int RT_SETUP = 2,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int PTR_W   = ADDR_W + 1,
  localparam int OCC_W   = PTR_W + 1,
  localparam int RT_W    = $clog2(RT_SETUP + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mrstN,
  input  logic              modeSel,
  input  logic              wrEnN,
  input  logic              rdEnN,
  input  logic              rtN,
  input  logic [ADDR_W-1:0] aeOffset,
  input  logic [ADDR_W-1:0] afOffset,
  output fifoStrobes_t      strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              readFlag,
  output logic              writeFlag,
  output logic              halfFullN,
  output logic              almostEmptyN,
  output logic              almostFullN
);

  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  localparam logic [OCC_W-1:0] DEPTH_O = OCC_W'(DEPTH);
  localparam logic [OCC_W-1:0] HALF_O  = OCC_W'(DEPTH / 2);
  localparam logic [RT_W-1:0]  RT_LOAD = RT_W'(RT_SETUP);

  fifoMode_e        modeReg;
  logic [PTR_W-1:0] wrPtr, rdPtr, memCount;
  logic             outValid, fetchPend;
  logic [RT_W-1:0]  rtBusy;

  logic fwftMode, memEmpty, memFull, setupActive, rtStart, rtFinish;
  logic doWrite, stdRead, popOut, refill, fetchDone, fetchStart, memRead;
  logic [OCC_W-1:0] occupancy, afLimit;

  // Style capture: sampled on clock edges while master reset is held.
  always_ff @(posedge clk) begin
    if (!mrstN) modeReg <= modeSel ? MODE_FALLTHRU : MODE_STANDARD;
  end

  always_comb begin
    fwftMode    = (modeReg == MODE_FALLTHRU);
    memCount    = wrPtr - rdPtr;
    memEmpty    = (memCount == '0);
    memFull     = (memCount == DEPTH_P);
    setupActive = (rtBusy != '0);
    rtStart     = !rtN && rdEnN && wrEnN && !setupActive;
    rtFinish    = fwftMode && (rtBusy == RT_W'(1)) && !memEmpty;
    doWrite     = !wrEnN && !memFull && !setupActive;
    stdRead     = !fwftMode && !rdEnN && !memEmpty && !setupActive;
    popOut      = fwftMode && !rdEnN && outValid && !setupActive;
    refill      = popOut && !memEmpty;
    fetchDone   = fetchPend && !rtStart;
    fetchStart  = fwftMode && !outValid && !fetchPend && !memEmpty &&
                  !setupActive && !rtStart;
    memRead     = stdRead | refill | fetchDone | rtFinish;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      outValid  <= 1'b0;
      fetchPend <= 1'b0;
      rtBusy    <= '0;
    end else begin
      if (doWrite) wrPtr <= wrPtr + PTR_W'(1);

      if (rtStart)      rdPtr <= '0;
      else if (memRead) rdPtr <= rdPtr + PTR_W'(1);

      if (rtStart)          rtBusy <= RT_LOAD;
      else if (setupActive) rtBusy <= rtBusy - RT_W'(1);

      fetchPend <= fetchStart;

      if (rtStart)                    outValid <= 1'b0;
      else if (fetchDone || rtFinish) outValid <= 1'b1;
      else if (popOut && memEmpty)    outValid <= 1'b0;
    end
  end

  assign strobes.memWrite = doWrite;
  assign strobes.outLoad  = memRead;
  assign wrAddr           = wrPtr[ADDR_W-1:0];
  assign rdAddr           = rdPtr[ADDR_W-1:0];

  // Flags, decoded from registered state.
  always_comb begin
    occupancy    = OCC_W'(memCount) + OCC_W'(fwftMode && outValid);
    afLimit      = DEPTH_O - OCC_W'(afOffset);
    readFlag     = fwftMode ? !outValid : (!memEmpty && !setupActive);
    writeFlag    = fwftMode ? memFull : !memFull;
    halfFullN    = !(occupancy > HALF_O);
    almostEmptyN = !(occupancy <= OCC_W'(aeOffset));
    almostFullN  = !(occupancy >= afLimit);
  end

  // Storage never holds more than DEPTH words.
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    memCount <= DEPTH_P);

  // A write at full does not grow the count.
  assert_full_write_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memFull && !wrEnN) |=> (memCount <= $past(memCount)));

  // Style holds between master resets.
  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!mrstN)
    mrstN |=> $stable(modeReg));

  // Fall-through: a pending fetch shows a valid word on the next edge.
  assert_fall_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fetchPend && !rtStart) |=> (outValid && !readFlag));

  // Standard: the setup phase reports empty.
  assert_rt_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rtStart && !fwftMode) |=> !readFlag);

  // Fall-through: the setup ends with word zero valid.
  assert_rt_present_R10: assert property (@(posedge clk) disable iff (!rstN)
    rtFinish |=> (outValid && (rdPtr == PTR_W'(1))));

  // No write lands during the first setup cycle.
  assert_setup_blocks_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rtBusy == RT_LOAD && !wrEnN) |=> $stable(wrPtr));

endmodule

// File: rtl/dualModeFifo.sv
module dualModeFifo
  import fifoPkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int DEPTH    = 2048,
  parameter int RT_SETUP = 2,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              mrstN,
  input  logic              prstN,
  input  logic              modeSel,
  input  logic              wrEnN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEnN,
  input  logic              rtN,
  input  logic [ADDR_W-1:0] aeOffset,
  input  logic [ADDR_W-1:0] afOffset,
  output logic [DATA_W-1:0] rdData,
  output logic              readFlag,
  output logic              writeFlag,
  output logic              halfFullN,
  output logic              almostEmptyN,
  output logic              almostFullN
);

  logic              rstN;
  fifoStrobes_t      strobes;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  // Either reset clears the pointers, flags and output register.
  assign rstN = mrstN & prstN;

  fifoControl #(.DEPTH(DEPTH), .RT_SETUP(RT_SETUP)) ctrl (
    .clk(clk), .rstN(rstN), .mrstN(mrstN), .modeSel(modeSel),
    .wrEnN(wrEnN), .rdEnN(rdEnN), .rtN(rtN),
    .aeOffset(aeOffset), .afOffset(afOffset),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .readFlag(readFlag), .writeFlag(writeFlag), .halfFullN(halfFullN),
    .almostEmptyN(almostEmptyN), .almostFullN(almostFullN)
  );

  fifoDatapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );

  // Output register holds its value across a cycle with no load.
  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.outLoad |=> $stable(rdData));

endmodule

// File: tb/dualModeFifo_test.sv
module dualModeFifo_test;

  localparam int DEPTH = 32;
  localparam int AE    = 3;
  localparam int AF    = 2;

  logic       clk = 1'b0;
  logic       mrstN, prstN, modeSel, wrEnN, rdEnN, rtN;
  logic [8:0] wrData, rdData;
  logic [4:0] aeOffset, afOffset;
  logic       readFlag, writeFlag, halfFullN, almostEmptyN, almostFullN;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  dualModeFifo #(.DEPTH(DEPTH)) uut (
    .clk(clk), .mrstN(mrstN), .prstN(prstN), .modeSel(modeSel),
    .wrEnN(wrEnN), .wrData(wrData), .rdEnN(rdEnN), .rtN(rtN),
    .aeOffset(aeOffset), .afOffset(afOffset), .rdData(rdData),
    .readFlag(readFlag), .writeFlag(writeFlag), .halfFullN(halfFullN),
    .almostEmptyN(almostEmptyN), .almostFullN(almostFullN)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    wrEnN = 1'b1; rdEnN = 1'b1; rtN = 1'b1;
  endtask

  task automatic masterReset(input bit mode);
    idle(); mrstN = 1'b0; modeSel = mode;
    repeat (3) step();
    mrstN = 1'b1; modeSel = ~mode;
  endtask

  task automatic partialReset(input bit otherMode);
    idle(); prstN = 1'b0; modeSel = otherMode;
    repeat (2) step();
    prstN = 1'b1;
  endtask

  task automatic wr(input logic [8:0] d);
    wrEnN = 1'b0; wrData = d; step(); wrEnN = 1'b1;
  endtask

  task automatic rd();
    rdEnN = 1'b0; step(); rdEnN = 1'b1;
  endtask

  task automatic resetFlags(input string req, input bit fwft);
    chk({req, " readFlag"},  readFlag, fwft ? 1 : 0);
    chk({req, " writeFlag"}, writeFlag, fwft ? 0 : 1);
    chk({req, " halfFullN"}, halfFullN, 1);
    chk({req, " almostEmptyN"}, almostEmptyN, 0);
    chk({req, " almostFullN"}, almostFullN, 1);
    chk({req, " rdData"}, rdData, 0);
  endtask

  function automatic bit expHF(int n);  return !(n > DEPTH/2);     endfunction
  function automatic bit expAE(int n);  return !(n <= AE);         endfunction
  function automatic bit expAF(int n);  return !(n >= DEPTH - AF); endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin : main
    int q[$];
    int n;
    void'($urandom(32'd7741));
    mrstN = 1'b0; prstN = 1'b1; modeSel = 1'b0; wrData = '0;
    aeOffset = 5'(AE); afOffset = 5'(AF);
    idle();

    // ---------- standard style ----------
    masterReset(0);
    resetFlags("R1 std", 0);
    rd();
    chk("R5 empty read rdData", rdData, 0);
    chk("R5 empty read readFlag", readFlag, 0);
    wr(9'h011); wr(9'h022); wr(9'h033);
    chk("R3 data present", readFlag, 1);
    rd(); chk("R3 order 1", rdData, 9'h011);
    rd(); chk("R3 order 2", rdData, 9'h022);
    rd(); chk("R3 order 3", rdData, 9'h033);
    chk("R3 drained", readFlag, 0);
    rd(); chk("R5 read empty holds", rdData, 9'h033);

    for (int i = 1; i <= DEPTH; i++) begin
      wr(9'(i + 9'h040));
      if (i == AE)          chk("R7 ae at offset", almostEmptyN, 0);
      if (i == AE + 1)      chk("R7 ae above offset", almostEmptyN, 1);
      if (i == DEPTH/2)     chk("R6 hf at half", halfFullN, 1);
      if (i == DEPTH/2 + 1) chk("R6 hf above half", halfFullN, 0);
      if (i == DEPTH-AF-1)  chk("R7 af below", almostFullN, 1);
      if (i == DEPTH-AF)    chk("R7 af at limit", almostFullN, 0);
      if (i == DEPTH-1)     chk("R3 not yet full", writeFlag, 1);
    end
    chk("R3 full flag", writeFlag, 0);
    wr(9'h1FF);
    chk("R5 still full", writeFlag, 0);
    for (int i = 1; i <= DEPTH; i++) begin
      rd(); chk("R5 full-write ignored order", rdData, 9'(i + 9'h040));
    end
    chk("R5 empty after drain", readFlag, 0);

    // retransmit, standard style
    masterReset(0);
    for (int i = 0; i < 4; i++) wr(9'(9'h0A0 + i));
    rd(); rd();
    chk("R9 pre-rt data", rdData, 9'h0A1);
    rtN = 1'b0; step(); rtN = 1'b1;
    chk("R9 setup cycle 1", readFlag, 0);
    wrEnN = 1'b0; wrData = 9'h155; step(); wrEnN = 1'b1;
    chk("R9 setup cycle 2", readFlag, 0);
    step();
    chk("R9 setup end", readFlag, 1);
    chk("R9 no auto read", rdData, 9'h0A1);
    for (int i = 0; i < 4; i++) begin
      rd(); chk("R9 replay order", rdData, 9'(9'h0A0 + i));
    end
    chk("R11 setup write ignored", readFlag, 0);

    // partial reset keeps standard style
    wr(9'h0E1); wr(9'h0E2);
    partialReset(1);
    resetFlags("R8 std", 0);
    wr(9'h077);
    chk("R8 std style kept flag", readFlag, 1);
    chk("R8 std no fall-through", rdData, 0);
    rd(); chk("R8 std read", rdData, 9'h077);

    // ---------- fall-through style ----------
    masterReset(1);
    resetFlags("R1 fwft", 1);
    wr(9'h05A);
    chk("R4 edge 1", readFlag, 1);
    step(); chk("R4 edge 2", readFlag, 1);
    step(); chk("R4 edge 3 flag", readFlag, 0);
    chk("R4 edge 3 data", rdData, 9'h05A);
    wr(9'h05B); wr(9'h05C);
    chk("R4 head held", rdData, 9'h05A);
    rd(); chk("R4 next word", rdData, 9'h05B);
    rd(); chk("R4 last word", rdData, 9'h05C);
    chk("R4 last valid", readFlag, 0);
    rd(); chk("R4 emptied", readFlag, 1);
    rd(); chk("R5 fwft empty read", rdData, 9'h05C);

    masterReset(1);
    wr(9'h0C0); wr(9'h0C1); wr(9'h0C2);
    chk("R4 head", rdData, 9'h0C0);
    rd(); chk("R10 pre-rt", rdData, 9'h0C1);
    rtN = 1'b0; step(); rtN = 1'b1;
    chk("R10 setup 1", readFlag, 1);
    wrEnN = 1'b0; wrData = 9'h1AA; step(); wrEnN = 1'b1;
    chk("R10 setup 2", readFlag, 1);
    step();
    chk("R10 end flag", readFlag, 0);
    chk("R10 word zero", rdData, 9'h0C0);
    rd(); chk("R10 replay 1", rdData, 9'h0C1);
    rd(); chk("R10 replay 2", rdData, 9'h0C2);
    rd(); chk("R11 fwft no extra word", readFlag, 1);

    partialReset(0);
    resetFlags("R8 fwft", 1);
    wr(9'h099); step(); step();
    chk("R8 fwft style kept", readFlag, 0);
    chk("R8 fwft data", rdData, 9'h099);

    // ---------- random, standard style ----------
    masterReset(0);
    q.delete();
    for (int c = 0; c < 3000; c++) begin
      bit w, r;
      int pre;
      logic [8:0] d;
      int wBias = ((c / 300) % 2 == 0) ? 3 : 1;
      w = ($urandom % 4) < wBias;
      r = ($urandom % 4) < (4 - wBias);
      d = 9'($urandom);
      modeSel = 1'($urandom);
      wrEnN = !w; rdEnN = !r; wrData = d;
      pre = q.size();
      step();
      if (r && pre > 0) begin
        n = q.pop_front();
        chk("R3 random read", rdData, n);
      end
      if (w && pre < DEPTH) q.push_back(d);
      chk("R3 random readFlag", readFlag, q.size() > 0);
      chk("R3 random writeFlag", writeFlag, q.size() < DEPTH);
      chk("R6 random halfFullN", halfFullN, expHF(q.size()));
      chk("R7 random almostEmptyN", almostEmptyN, expAE(q.size()));
      chk("R7 random almostFullN", almostFullN, expAF(q.size()));
    end
    idle();
    chk("R2 style unchanged by modeSel", readFlag, q.size() > 0);

    // ---------- random, fall-through style ----------
    masterReset(1);
    q.delete();
    for (int c = 0; c < 3000; c++) begin
      bit w, r;
      logic [8:0] d;
      int wBias = ((c / 250) % 2 == 0) ? 3 : 1;
      w = ($urandom % 4) < wBias;
      r = ($urandom % 4) < (4 - wBias);
      d = 9'($urandom);
      modeSel = 1'($urandom);
      wrEnN = !w; rdEnN = !r; wrData = d;
      if (r && readFlag == 1'b0) begin
        if (q.size() == 0) chk("R4 random spurious word", 1, 0);
        else begin
          n = q.pop_front();
          chk("R4 random head", rdData, n);
        end
      end
      if (w && writeFlag == 1'b0) q.push_back(d);
      step();
    end
    idle();
    for (int c = 0; c < 4 * DEPTH; c++) begin
      rdEnN = 1'b0;
      if (readFlag == 1'b0) begin
        n = (q.size() > 0) ? q.pop_front() : -1;
        chk("R4 drain head", rdData, n);
      end
      step();
    end
    idle();
    chk("R4 drain complete", q.size(), 0);
    chk("R2 fwft style kept", readFlag, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule